// File: doc/BRIEF.md
# Lock-Step Interleaved Read Memory

This block stores words in 2^BANK_BITS banks, with consecutive addresses placed in consecutive banks. The low BANK_BITS of an address pick the bank and the high ROW_BITS pick the row inside every bank. One row address is applied to all banks together. After ACC_CYC cycles, each bank's word is captured in that bank's own output data register. The captured words then leave one per cycle on a single output stream, lowest bank first.

A client asks for a sequential burst by giving a start address and a word count. The control issues the following row to the banks while the current row is still draining from the data registers. The new row lands in the registers in the same cycle that the last word of the previous row is sent. After the first row arrives, a burst therefore streams without gaps. If the start address is not bank-aligned, the first row is entered part way along and the leading banks are skipped.

The banks are behavioural and read-only, and each bank has a fixed access time. With the defaults there are 4 banks, 16 rows, 16-bit words and 3-cycle access, so the address is 6 bits and a burst holds 1 to 63 words.

Top module: `ilvSyncMem`

## Requirements
- R1: The word at address a (a being the 6-bit value {row, bank}, bank = a[1:0], row = a[5:2]) reads as ((a * 257) mod 2^16) XOR 0x5A3C.
- R2: While rstN is low, and in the cycle after rstN is released, outValid is 0 and reqReady is 1. A reset in the middle of a burst ends the burst.
- R3: A request is taken on a rising edge where reqValid, reqReady and a nonzero reqLen are all high. reqReady is low from the next cycle until the burst ends. Any reqValid seen while reqReady is low has no effect, and the burst already under way is unchanged.
- R4: When a request is taken on edge E, outValid first goes high after edge E+ACC_CYC-1, which is ACC_CYC cycles after the request cycle. That first word is the one at the start address.
- R5: A burst of L words puts out the words at addresses a, a+1, ..., a+L-1, taken modulo 64. It does so on exactly L consecutive cycles with no gap, and outValid then falls.
- R6: A start address with a nonzero bank field begins at that bank and carries on into bank 0 of the following row.
- R7: reqReady is high again in the cycle after the last word of a burst, so a new request can be taken in that cycle (back-to-back bursts).
- R8: A request with reqLen equal to 0 is ignored. No word is put out and reqReady stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Burst request present |
| reqAddr | input | 6 | Start word address, bank in [1:0], row in [5:2] |
| reqLen | input | 6 | Burst length in words |
| reqReady | output | 1 | High when a request can be taken |
| outValid | output | 1 | Output word valid |
| outData | output | 16 | Output word |

## Verification
After the accepting edge, the bench expects ACC_CYC-1 cycles with outValid low. The first word is due in the ACC_CYC-th cycle, each later word one cycle after the one before, and outValid low together with reqReady high in the cycle after the last word. All sampling happens on the falling clock edge, so every register update from the preceding rising edge has settled. The bench counts those exact cycles and never polls for a value. Bursts run back to back, so a late ready or an extra cycle of output shows up as a failed check.

// File: rtl/ilvPkg.sv
package ilvPkg;
  // Per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic fetchEn;   // present a row address to every bank this cycle
    logic streamEn;  // a word is leaving the data registers this cycle
  } ilvStrb_t;

  // Fixed read-only contents of the behavioural banks
  localparam int CELL_MUL = 257;
  localparam int CELL_XOR = 'h5A3C;
endpackage

// File: rtl/ilvBank.sv
module ilvBank
  import ilvPkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 4,
  parameter int WORD_W    = 16,
  parameter int ACC_CYC   = 3,
  parameter int BANK_IDX  = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fetchEn,
  input  logic [ROW_BITS-1:0] fetchRow,
  output logic                rdValid,
  output logic [WORD_W-1:0]   rdData
);
  localparam logic [BANK_BITS-1:0] BSEL = BANK_BITS'(BANK_IDX);

  function automatic logic [WORD_W-1:0] cellWord(input logic [ROW_BITS-1:0] row);
    logic [31:0] a;
    a = 32'({row, BSEL});
    return WORD_W'(a * 32'(CELL_MUL)) ^ WORD_W'(CELL_XOR);
  endfunction

  generate
    if (ACC_CYC == 1) begin : g_direct
      assign rdValid = fetchEn;
      assign rdData  = cellWord(fetchRow);
    end else begin : g_piped
      localparam int STAGES = ACC_CYC - 1;
      logic [STAGES-1:0]   vPipe;
      logic [ROW_BITS-1:0] rowPipe [STAGES];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          vPipe <= '0;
          for (int s = 0; s < STAGES; s++) rowPipe[s] <= '0;
        end else begin
          vPipe[0]   <= fetchEn;
          rowPipe[0] <= fetchRow;
          for (int s = 1; s < STAGES; s++) begin
            vPipe[s]   <= vPipe[s-1];
            rowPipe[s] <= rowPipe[s-1];
          end
        end
      end

      assign rdValid = vPipe[STAGES-1];
      assign rdData  = cellWord(rowPipe[STAGES-1]);
    end
  endgenerate
endmodule

// File: rtl/ilvDatapath.sv
module ilvDatapath
  import ilvPkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 4,
  parameter int WORD_W    = 16,
  parameter int ACC_CYC   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ilvStrb_t             strb,
  input  logic [ROW_BITS-1:0]  fetchRow,
  input  logic [BANK_BITS-1:0] outBank,
  output logic [WORD_W-1:0]    outData
);
  localparam int NB = 1 << BANK_BITS;

  logic [NB-1:0]     rdValid;
  logic [WORD_W-1:0] rdData [NB];
  logic [WORD_W-1:0] mdr    [NB];

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      ilvBank #(
        .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .WORD_W(WORD_W),
        .ACC_CYC(ACC_CYC), .BANK_IDX(b)
      ) i_bank (
        .clk(clk), .rstN(rstN), .fetchEn(strb.fetchEn), .fetchRow(fetchRow),
        .rdValid(rdValid[b]), .rdData(rdData[b])
      );

      always_ff @(posedge clk) begin
        if (!rstN) mdr[b] <= '0;
        else if (rdValid[b]) mdr[b] <= rdData[b];
      end
    end
  endgenerate

  assign outData = mdr[outBank];

  // R4
  first_word_loaded_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.streamEn) |-> $past(rdValid[0]));

  // R5
  reload_row_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid[0] && strb.streamEn) |-> (outBank == BANK_BITS'(NB - 1)));
endmodule

// File: rtl/ilvControl.sv
module ilvControl
  import ilvPkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 4,
  parameter int LEN_W     = 6,
  parameter int ACC_CYC   = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [BANK_BITS+ROW_BITS-1:0] reqAddr,
  input  logic [LEN_W-1:0]              reqLen,
  output logic                          reqReady,
  output ilvStrb_t                      strb,
  output logic [ROW_BITS-1:0]           fetchRow,
  output logic [BANK_BITS-1:0]          outBank
);
  localparam int ADDR_W = BANK_BITS + ROW_BITS;
  localparam int NB     = 1 << BANK_BITS;
  localparam int GAP_W  = BANK_BITS + 1;
  localparam int CNT_W  = $clog2(ACC_CYC + 1);

  logic                 busy, streamOn, waitOn, fetchActive;
  logic [CNT_W-1:0]     startCnt;
  logic [BANK_BITS-1:0] outBankQ;
  logic [LEN_W-1:0]     outLeft, toFetch;
  logic [ROW_BITS-1:0]  nextRow;
  logic [GAP_W-1:0]     gapCnt;

  logic                 accept, gapHit;
  logic [BANK_BITS-1:0] reqOff;
  logic [ROW_BITS-1:0]  reqRow;
  logic [LEN_W-1:0]     firstRoom, firstTake, nextTake;

  always_comb begin
    reqOff    = reqAddr[BANK_BITS-1:0];
    reqRow    = reqAddr[ADDR_W-1:BANK_BITS];
    firstRoom = LEN_W'(NB) - LEN_W'(reqOff);
    firstTake = (reqLen < firstRoom) ? reqLen : firstRoom;
    nextTake  = (toFetch < LEN_W'(NB)) ? toFetch : LEN_W'(NB);
    accept    = reqValid && !busy && (reqLen != '0);
    gapHit    = fetchActive && (gapCnt == GAP_W'(1));
  end

  // Row issue schedule: the next row goes out as many cycles after the
  // previous issue as that previous row has words to stream.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchActive <= 1'b0;
      nextRow     <= '0;
      toFetch     <= '0;
      gapCnt      <= '0;
    end else if (accept) begin
      nextRow     <= reqRow + ROW_BITS'(1);
      toFetch     <= reqLen - firstTake;
      gapCnt      <= GAP_W'(firstTake);
      fetchActive <= reqLen > firstTake;
    end else if (gapHit) begin
      nextRow     <= nextRow + ROW_BITS'(1);
      toFetch     <= toFetch - nextTake;
      gapCnt      <= GAP_W'(nextTake);
      fetchActive <= toFetch > nextTake;
    end else if (fetchActive) begin
      gapCnt      <= gapCnt - GAP_W'(1);
    end
  end

  // Stream launch and word counting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      streamOn <= 1'b0;
      waitOn   <= 1'b0;
      startCnt <= '0;
      outBankQ <= '0;
      outLeft  <= '0;
    end else begin
      if (accept) begin
        busy     <= 1'b1;
        outBankQ <= reqOff;
        outLeft  <= reqLen;
        if (ACC_CYC == 1) begin
          streamOn <= 1'b1;
        end else begin
          waitOn   <= 1'b1;
          startCnt <= CNT_W'(ACC_CYC - 1);
        end
      end
      if (waitOn) begin
        if (startCnt == CNT_W'(1)) begin
          waitOn   <= 1'b0;
          streamOn <= 1'b1;
        end else begin
          startCnt <= startCnt - CNT_W'(1);
        end
      end
      if (streamOn) begin
        outBankQ <= outBankQ + BANK_BITS'(1);
        outLeft  <= outLeft - LEN_W'(1);
        if (outLeft == LEN_W'(1)) begin
          streamOn <= 1'b0;
          busy     <= 1'b0;
        end
      end
    end
  end

  assign reqReady      = !busy;
  assign strb.fetchEn  = accept || gapHit;
  assign strb.streamEn = streamOn;
  assign fetchRow      = accept ? reqRow : nextRow;
  assign outBank       = outBankQ;

  // R3
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLen != '0) |=> !reqReady);

  // R3
  pending_rows_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchActive |-> !reqReady);

  // R5
  stream_gapless_chk: assert property (@(posedge clk) disable iff (!rstN)
    (streamOn && outLeft != LEN_W'(1)) |=> streamOn);

  // R7
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(streamOn) |-> reqReady);
endmodule

// File: rtl/ilvSyncMem.sv
module ilvSyncMem
  import ilvPkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 4,
  parameter int WORD_W    = 16,
  parameter int LEN_W     = 6,
  parameter int ACC_CYC   = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [BANK_BITS+ROW_BITS-1:0] reqAddr,
  input  logic [LEN_W-1:0]              reqLen,
  output logic                          reqReady,
  output logic                          outValid,
  output logic [WORD_W-1:0]             outData
);
  localparam int NB = 1 << BANK_BITS;

  generate
    if (NB < ACC_CYC) begin : g_tooFewBanks
      $error("bank count must be at least the bank access time");
    end
    if (LEN_W <= BANK_BITS) begin : g_lenTooNarrow
      $error("length field must be wider than the bank field");
    end
  endgenerate

  ilvStrb_t             strb;
  logic [ROW_BITS-1:0]  fetchRow;
  logic [BANK_BITS-1:0] outBank;

  ilvControl #(
    .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .LEN_W(LEN_W), .ACC_CYC(ACC_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqReady(reqReady), .strb(strb),
    .fetchRow(fetchRow), .outBank(outBank)
  );

  ilvDatapath #(
    .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .WORD_W(WORD_W), .ACC_CYC(ACC_CYC)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchRow(fetchRow),
    .outBank(outBank), .outData(outData)
  );

  assign outValid = strb.streamEn;
endmodule

// File: tb/test_ilvSyncMem.sv
`timescale 1ns/1ps
module test_ilvSyncMem;
  localparam int ACC = 3;
  localparam int AW  = 6;
  localparam int LW  = 6;

  function automatic logic [15:0] expWord(input int a);
    int m;
    m = a & 63;
    return 16'((m * 257) & 'hFFFF) ^ 16'h5A3C;
  endfunction

  // {addr[5:0], len[5:0], expected first word[15:0]}
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {6'd0,  6'd4,  expWord(0)},
    {6'd5,  6'd1,  expWord(5)},
    {6'd2,  6'd7,  expWord(2)},
    {6'd7,  6'd9,  expWord(7)},
    {6'd60, 6'd10, expWord(60)},
    {6'd0,  6'd63, expWord(0)},
    {6'd1,  6'd2,  expWord(1)},
    {6'd3,  6'd5,  expWord(3)}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic          reqReady, outValid;
  logic [15:0]   outData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ilvSyncMem i_ilvSyncMem (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqReady(reqReady), .outValid(outValid), .outData(outData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge with reqReady expected high; returns at the
  // falling edge of the cycle after the last word.
  task automatic runBurst(input int addr, input int len, input int firstExp,
                          input bit noise);
    chk(reqReady === 1'b1, "R7", "ready before request", int'(reqReady), 1);
    reqValid = 1'b1;
    reqAddr  = AW'(addr);
    reqLen   = LW'(len);
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      reqAddr = AW'(addr + 17);
      reqLen  = LW'(5);
    end else begin
      reqValid = 1'b0;
    end
    for (int k = 1; k < ACC; k++) begin
      chk(outValid === 1'b0, "R4", "no word before access time", int'(outValid), 0);
      chk(reqReady === 1'b0, "R3", "ready low while busy", int'(reqReady), 0);
      @(negedge clk);
    end
    for (int w = 0; w < len; w++) begin
      chk(outValid === 1'b1, "R5", "valid during burst", int'(outValid), 1);
      if (w == 0) begin
        chk(outData === firstExp[15:0], "R4", "first word", int'(outData), firstExp);
        if ((addr & 3) != 0)
          chk(outData === expWord(addr), "R6", "offset start bank", int'(outData),
              int'(expWord(addr)));
      end else begin
        chk(outData === expWord(addr + w), "R1", "word content", int'(outData),
            int'(expWord(addr + w)));
      end
      if (noise && w == len - 1) reqValid = 1'b0;
      @(negedge clk);
    end
    chk(outValid === 1'b0, "R5", "valid ends after len words", int'(outValid), 0);
    chk(reqReady === 1'b1, "R7", "ready after last word", int'(reqReady), 1);
  endtask

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    chk(outValid === 1'b0, "R2", "valid in reset", int'(outValid), 0);
    chk(reqReady === 1'b1, "R2", "ready in reset", int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid === 1'b0, "R2", "valid after reset", int'(outValid), 0);

    // Table walk, bursts back to back (R1, R4, R5, R6, R7)
    for (int i = 0; i < NV; i++)
      runBurst(int'(VEC[i][27:22]), int'(VEC[i][21:16]), int'(VEC[i][15:0]), 1'b0);

    // R3: request held high during a burst is ignored
    runBurst(9, 6, int'(expWord(9)), 1'b1);
    for (int k = 0; k < ACC + 2; k++) begin
      chk(outValid === 1'b0, "R3", "no burst from ignored request", int'(outValid), 0);
      @(negedge clk);
    end

    // R8: zero length request ignored
    reqValid = 1'b1;
    reqAddr  = AW'(3);
    reqLen   = '0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady === 1'b1, "R8", "ready after zero length", int'(reqReady), 1);
    for (int k = 0; k < ACC + 2; k++) begin
      chk(outValid === 1'b0, "R8", "no word for zero length", int'(outValid), 0);
      @(negedge clk);
    end

    // R2: reset in the middle of a burst
    reqValid = 1'b1;
    reqAddr  = AW'(20);
    reqLen   = LW'(12);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (ACC + 2) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(outValid === 1'b0, "R2", "reset ends burst", int'(outValid), 0);
    chk(reqReady === 1'b1, "R2", "ready after reset", int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    runBurst(33, 3, int'(expWord(33)), 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not end actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule